// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a synchronous up-counter built from 4-bit slices. Each slice counts modulo 16, can be preset from a data word on the rising clock edge, and has two count enables. Counting requires both the parallel enable and the trickle enable. Only the trickle enable also gates the slice's terminal-count flag. The flag is high while the trickle enable is high and the slice holds its largest value.

The top module chains a parameter-set number of slices. Stage 0 takes the external trickle enable. Each later stage takes the terminal-count flag of the stage below it as its trickle enable. All stages share the clock, the parallel enable, the load strobe and the reset, so the chain behaves as one wide binary counter. The master reset is active low and asynchronous. It overrides loading and counting and clears the whole count at once. The load strobe is active low and wins over both count enables. The top presents the full count and the terminal-count flag of the last stage.

Top module: `casc_counter`

## Requirements
- R1: While `mr_n` is low, `q` is all zeros. It clears as soon as `mr_n` falls, without waiting for a clock edge, and a low `mr_n` overrides load and count.
- R2: On a rising edge with `ld_n` low, `q` takes the value of `din`, whatever `en_par` and `en_trk` are.
- R3: On a rising edge with `ld_n` high and both `en_par` and `en_trk` high, the lowest slice advances by one.
- R4: A slice at 15 that counts goes to 0.
- R5: On a rising edge with `ld_n` high and either `en_par` or `en_trk` low, `q` keeps its value.
- R6: A slice's terminal count is high exactly when its trickle enable is high and its state is 15. `en_par` does not affect it, so a slice with a high terminal count wraps to 0 on the next counting edge.
- R7: Stage k above 0 receives the terminal count of stage k-1 as its trickle enable, so the chain counts as one binary number modulo 2^(4·STAGES). An upper stage stays still while any lower stage is below 15.
- R8: `tc_out` is high exactly when `en_trk` is high and every bit of `q` is 1.
- R9: Stage k occupies bits [4k+3:4k] of both `din` and `q`. Stage 0 holds the least significant bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| mr_n | input | 1 | Asynchronous master reset, active low |
| ld_n | input | 1 | Synchronous preset strobe, active low |
| din | input | 4·STAGES | Preset word, stage 0 in the low bits |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_trk | input | 1 | Trickle count enable into stage 0 |
| q | output | 4·STAGES | Counter state |
| tc_out | output | 1 | Terminal count of the last stage |

## Verification
The three-stage counter is stepped through its entire 4096-state cycle with both enables high. This exposes any slice that fails to wrap or any carry that reaches an upper stage too early or too late, for example at 0x0FF to 0x100 and 0xFFF to 0x000. Each enable is then dropped on its own at the all-ones state. With only the parallel enable low, the counter must hold while `tc_out` stays high. With only the trickle enable low, the counter must hold and `tc_out` must fall. Preloads with one value placed in each stage position check the bit placement of `din` and `q` and that loading beats counting. A reset dropped in the middle of a clock period must clear the count before the next edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_LOAD = 2'd2
    } op_e;

    typedef struct packed {
        logic ld_n;
        logic ep;
        logic et;
    } ctl_t;

    function automatic op_e pick_op(input ctl_t c);
        if (!c.ld_n)
            return OP_LOAD;
        else if (c.ep && c.et)
            return OP_INC;
        else
            return OP_HOLD;
    endfunction

    function automatic nib_t nib_inc(input nib_t v);
        return v + nib_t'(1);
    endfunction

    function automatic logic nib_full(input nib_t v);
        return &v;
    endfunction

endpackage

// File: rtl/cnt_ctl_dec.sv
module cnt_ctl_dec
    import cnt_pkg::*;
(
    input  ctl_t ctl,
    output op_e  op
);
    always_comb begin
        op = pick_op(ctl);
    end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
    import cnt_pkg::*;
(
    input  logic clk,
    input  logic mr_n,
    input  op_e  op,
    input  nib_t d,
    output nib_t q
);
    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n)
            q <= '0;
        else begin
            case (op)
                OP_LOAD: q <= d;
                OP_INC:  q <= nib_inc(q);
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
(
    input  logic clk,
    input  logic mr_n,
    input  logic ld_n,
    input  logic ep,
    input  logic et,
    input  nib_t d,
    output nib_t q,
    output logic tc
);
    ctl_t ctl;
    op_e  op;

    assign ctl = '{ld_n: ld_n, ep: ep, et: et};

    cnt_ctl_dec u_dec (
        .ctl (ctl),
        .op  (op)
    );

    cnt_state_reg u_reg (
        .clk  (clk),
        .mr_n (mr_n),
        .op   (op),
        .d    (d),
        .q    (q)
    );

    assign tc = et & nib_full(q);

    assert_load_R2: assert property (@(posedge clk) disable iff (!mr_n)
        !ld_n |=> q == $past(d));

    assert_inc_R3: assert property (@(posedge clk) disable iff (!mr_n)
        (ld_n && ep && et) |=> q == nib_t'($past(q) + 4'd1));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!mr_n)
        (ld_n && ep && et && q == 4'hF) |=> q == 4'h0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!mr_n)
        (ld_n && !(ep && et)) |=> $stable(q));

    assert_tc_wrap_R6: assert property (@(posedge clk) disable iff (!mr_n)
        (tc && ld_n && ep) |=> q == 4'h0);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import cnt_pkg::*;
#(
    parameter int STAGES = 3,
    localparam int W = STAGES * SLICE_W
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic         ld_n,
    input  logic [W-1:0] din,
    input  logic         en_par,
    input  logic         en_trk,
    output logic [W-1:0] q,
    output logic         tc_out
);
    logic [STAGES-1:0] tc_chain;
    logic [STAGES-1:0] et_chain;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign et_chain[k] = en_trk;
        end else begin : g_next
            assign et_chain[k] = tc_chain[k-1];
        end

        cnt_slice u_slice (
            .clk  (clk),
            .mr_n (mr_n),
            .ld_n (ld_n),
            .ep   (en_par),
            .et   (et_chain[k]),
            .d    (din[k*SLICE_W +: SLICE_W]),
            .q    (q[k*SLICE_W +: SLICE_W]),
            .tc   (tc_chain[k])
        );

        if (k > 0) begin : g_chk
            // R7: an upper stage stays still unless every lower stage is full
            assert_carry_R7: assert property (@(posedge clk) disable iff (!mr_n)
                (ld_n && !(&q[k*SLICE_W-1:0])) |=> $stable(q[k*SLICE_W +: SLICE_W]));
        end
    end

    assign tc_out = tc_chain[STAGES-1];

    assert_tc_full_R8: assert property (@(posedge clk) disable iff (!mr_n)
        tc_out |-> (en_trk && &q));
endmodule

// File: tb/tb_casc_counter.sv
module tb_casc_counter;
    localparam int STAGES = 3;
    localparam int W = STAGES * 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         mr_n = 1'b0;
    logic         ld_n = 1'b1;
    logic [W-1:0] din = '0;
    logic         en_par = 1'b0;
    logic         en_trk = 1'b0;
    logic [W-1:0] q;
    logic         tc_out;

    int checks = 0;
    int failures = 0;
    int exp_q = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    casc_counter #(.STAGES(STAGES)) dut (
        .clk(clk), .mr_n(mr_n), .ld_n(ld_n), .din(din),
        .en_par(en_par), .en_trk(en_trk), .q(q), .tc_out(tc_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one rising edge, model update, then compare away from the edge
    task automatic step(input string req);
        int nxt;
        if (!ld_n) nxt = int'(din);
        else if (en_par && en_trk) nxt = (exp_q + 1) & MASK;
        else nxt = exp_q;
        @(posedge clk);
        #2;
        exp_q = nxt;
        chk(req, int'(q), exp_q);
        chk({req, " tc"}, int'(tc_out), int'(en_trk && exp_q == MASK));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        din = 12'hABC; ld_n = 1'b0; en_par = 1'b1; en_trk = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        chk("R1 reset state", int'(q), 0);
        chk("R1 reset tc", int'(tc_out), 0);
        ld_n = 1'b1;
        @(negedge clk);
        mr_n = 1'b1;
        exp_q = 0;

        // R9/R2: one value per stage position, enables in all combinations
        for (int s = 0; s < STAGES; s++) begin
            for (int v = 1; v < 16; v++) begin
                din = W'(v << (4 * s));
                ld_n = 1'b0;
                en_par = v[0];
                en_trk = v[1];
                step("R2 R9 load");
            end
        end

        // R3/R4/R7: full cycle from zero, carry at 0x0FF and wrap at 0xFFF
        din = '0; ld_n = 1'b0; step("R2 load zero");
        ld_n = 1'b1; en_par = 1'b1; en_trk = 1'b1;
        for (int i = 0; i < (1 << W); i++) begin
            step("R3 R4 R7 count");
            if (exp_q == 12'h100) chk("R7 carry 0FF->100", int'(q), 12'h100);
        end
        chk("R4 R7 full wrap", int'(q), 0);

        // R5/R6/R8 at all ones
        din = W'(MASK); ld_n = 1'b0; step("R2 load ones");
        ld_n = 1'b1; en_par = 1'b0; en_trk = 1'b1;
        step("R5 hold par low");
        chk("R6 R8 tc ignores par", int'(tc_out), 1);
        en_par = 1'b1; en_trk = 1'b0;
        step("R5 hold trk low");
        chk("R8 tc needs trk", int'(tc_out), 0);
        en_trk = 1'b1; #1;
        chk("R6 tc comb", int'(tc_out), 1);
        step("R6 wrap after tc");

        // R2 priority: load while both enables high
        din = 12'h5A3; ld_n = 1'b0; step("R2 load over count");
        ld_n = 1'b1; step("R3 count after load");

        // R1: reset dropped mid-period, checked before next edge
        @(posedge clk);
        #3;
        mr_n = 1'b0;
        #1;
        chk("R1 async clear", int'(q), 0);
        @(posedge clk);
        #2;
        chk("R1 overrides count", int'(q), 0);
        @(negedge clk);
        mr_n = 1'b1;
        exp_q = 0;
        step("R3 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule